// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator Counter

This block is an 8-bit up-counter whose input comes from one external pin. A mode bit selects what the counter measures. In event mode the count advances once for every qualified transition of the pin. In gated mode the count advances on a tick taken once every 64 system-clock enables, but only while the pin sits at its active level, so the count measures how long the pin was active. A polarity bit picks the qualifying edge in event mode and the active level in gated mode.

The pin passes through a two-flop synchroniser that samples only on clock-enable cycles. The count is loaded through a write strobe and can be read at any time. When the count wraps from 0xFF to 0x00 a sticky overflow flag is set. The flag is cleared by writing a 1 to it, and it raises an interrupt request when the interrupt enable is on.

A small controller holds three named states. `ST_IDLE` is used while the block is disabled. `ST_EVENT` is used when the block is enabled with mode 0. `ST_GATED` is used when the block is enabled with mode 1. On every enabled clock the controller moves to whichever state the current `cfg_enable` and `cfg_mode` inputs select. This gives these transitions: IDLE→EVENT, IDLE→GATED, EVENT→GATED, GATED→EVENT, and EVENT/GATED→IDLE.

Top module: `edge_time_accum`

## Requirements
- R1: After reset the count reads 0x00, the overflow flag is 0 and the interrupt request is 0.
- R2: A write strobe (`cnt_wr`=1) loads `cnt_wdata` into the count at the next clock edge. This holds whatever the values of `clk_en` and `cfg_enable`, and the value reads back on `cnt_rdata`.
- R3: With `cfg_mode`=0 and `cfg_polarity`=0, each rising transition of `ext_in` adds one to the count. The new value is visible after the third enabled clock edge following the change.
- R4: With `cfg_mode`=0 and `cfg_polarity`=1, only falling transitions of `ext_in` are counted and rising ones are ignored.
- R5: In event mode, a pin that toggles on every enabled cycle (half the enable rate) has every qualifying edge counted.
- R6: With `cfg_mode`=1 the count advances once per 64 enabled cycles while the synchronised pin is active: high for `cfg_polarity`=0, low for `cfg_polarity`=1. The first increment lands on the 65th enabled edge after `cfg_enable` rises.
- R7: In gated mode, a pin held at its inactive level leaves the count unchanged.
- R8: While `cfg_enable`=0 the count holds, pin activity is ignored and the divide-by-64 prescaler is held in reset, so its phase restarts on re-enable.
- R9: While `clk_en`=0 nothing advances, and a pin pulse that starts and ends inside such an interval is never counted.
- R10: An increment from 0xFF gives 0x00 and sets `ovf_flag`, which stays set until it is cleared.
- R11: `flag_wr`=1 with `flag_wdata`=1 clears the flag, and `flag_wdata`=0 has no effect. If a wrap and a clear fall in the same cycle, the flag ends set.
- R12: `ovf_irq` is 1 exactly when `ovf_flag`=1 and `cfg_irq_en`=1.
- R13: If a count write and an increment fall on the same edge, the written value is loaded, the increment is dropped and no overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable that qualifies every counting cycle |
| ext_in | input | 1 | External pulse/gate pin (asynchronous) |
| cfg_enable | input | 1 | Block enable |
| cfg_mode | input | 1 | 0 = event counting, 1 = gated time |
| cfg_polarity | input | 1 | 0 = rising edge / active high, 1 = falling edge / active low |
| cfg_irq_en | input | 1 | Overflow interrupt enable |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Value to load into the count |
| cnt_rdata | output | 8 | Current count |
| flag_wr | input | 1 | Overflow flag write strobe |
| flag_wdata | input | 1 | Flag write data; 1 clears the flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A pin change reaches the count three enabled edges later: two synchroniser flops, then the edge register that feeds the count. The bench therefore holds each pattern bit for two cycles and waits six cycles before reading. The exact three-edge latency is probed once, with samples taken at edge two and at edge three. A gated increment is due on the 65th enabled edge after enable, because the controller takes one edge and the prescaler takes 64 more. The bench samples after 64 edges and again after 65. Writes, flag clears and the interrupt all settle one edge after the strobe, or combinationally for the interrupt. All values are sampled on the falling clock edge.

// File: rtl/eta_pkg.sv
package eta_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVENT = 2'd1,
        ST_GATED = 2'd2
    } eta_state_e;

endpackage

// File: rtl/eta_input_stage.sv
module eta_input_stage #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic pin,
    input  logic polarity,
    output logic level_act,
    output logic edge_act
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] sync_q;
    logic         last_q;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)      sync_q[0] <= 1'b0;
                    else if (clk_en) sync_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)      sync_q[g] <= 1'b0;
                    else if (clk_en) sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      last_q <= 1'b0;
        else if (clk_en) last_q <= sync_q[MSB];
    end

    assign level_act = sync_q[MSB] ^ polarity;
    assign edge_act  = level_act & ~(last_q ^ polarity);

    // One qualified edge cannot be reported on two consecutive enabled cycles.
    assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && edge_act) |=> !edge_act);

endmodule

// File: rtl/eta_prescaler.sv
module eta_prescaler #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_en,
    input  logic run,
    output logic tick
);
    localparam int            PW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          div_q <= '0;
        else if (!run)       div_q <= '0;
        else if (clk_en)     div_q <= (div_q == LAST) ? '0 : div_q + ONE;
    end

    assign tick = run & clk_en & (div_q == LAST);

    assert_tick_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    assert_held_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (div_q == '0));

endmodule

// File: rtl/eta_count_reg.sv
module eta_count_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic         flag_clr,
    output logic [W-1:0] count,
    output logic         flag
);
    localparam logic [W-1:0] ONE = W'(1);

    logic wrap;

    assign wrap = step & ~wr & (count == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    count <= '0;
        else if (wr)   count <= wdata;
        else if (step) count <= count + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end

    assert_write_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (count == $past(wdata)));

    assert_step_adds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr) |=> (count == $past(count) + ONE));

    assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr && count == '1) |=> (flag && count == '0));

    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(step && !wr && count == '1)) |=> !flag);

endmodule

// File: rtl/edge_time_accum.sv
module edge_time_accum #(
    parameter int CNT_W        = 8,
    parameter int PRESCALE_DIV = 64,
    parameter int SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             ext_in,
    input  logic             cfg_enable,
    input  logic             cfg_mode,
    input  logic             cfg_polarity,
    input  logic             cfg_irq_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             flag_wr,
    input  logic             flag_wdata,
    output logic             ovf_flag,
    output logic             ovf_irq
);
    import eta_pkg::*;

    eta_state_e state_q, state_d;
    logic       level_act, edge_act, tick;
    logic       count_step, pre_run;

    eta_input_stage #(.SYNC_STAGES(SYNC_STAGES)) u_input (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .pin       (ext_in),
        .polarity  (cfg_polarity),
        .level_act (level_act),
        .edge_act  (edge_act)
    );

    eta_prescaler #(.DIV(PRESCALE_DIV)) u_prescale (
        .clk    (clk),
        .rst_n  (rst_n),
        .clk_en (clk_en),
        .run    (pre_run),
        .tick   (tick)
    );

    eta_count_reg #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cnt_wr),
        .wdata    (cnt_wdata),
        .step     (count_step),
        .flag_clr (flag_wr & flag_wdata),
        .count    (cnt_rdata),
        .flag     (ovf_flag)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (clk_en) state_q <= state_d;
    end

    // Next state: every state follows the configuration inputs
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_EVENT, ST_GATED: begin
                if (!cfg_enable)   state_d = ST_IDLE;
                else if (cfg_mode) state_d = ST_GATED;
                else               state_d = ST_EVENT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        count_step = 1'b0;
        pre_run    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                count_step = 1'b0;
                pre_run    = 1'b0;
            end
            ST_EVENT: begin
                count_step = clk_en & edge_act;
                pre_run    = 1'b0;
            end
            ST_GATED: begin
                count_step = tick & level_act;
                pre_run    = 1'b1;
            end
            default: begin
                count_step = 1'b0;
                pre_run    = 1'b0;
            end
        endcase
    end

    assign ovf_irq = ovf_flag & cfg_irq_en;

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cnt_wr) |=> $stable(cnt_rdata));

    assert_no_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !cnt_wr) |=> $stable(cnt_rdata));

    assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !ovf_irq);

    assert_legal_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);

endmodule

// File: tb/edge_time_accum_test.sv
module edge_time_accum_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       ext_in = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       cfg_polarity = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic       cnt_wr = 1'b0;
    logic [7:0] cnt_wdata = 8'h00;
    logic [7:0] cnt_rdata;
    logic       flag_wr = 1'b0;
    logic       flag_wdata = 1'b0;
    logic       ovf_flag;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    edge_time_accum uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ext_in(ext_in),
        .cfg_enable(cfg_enable), .cfg_mode(cfg_mode), .cfg_polarity(cfg_polarity),
        .cfg_irq_en(cfg_irq_en), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cnt_rdata(cnt_rdata), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .ovf_flag(ovf_flag), .ovf_irq(ovf_irq)
    );

    // {polarity, pattern (bit 15 played first), start count}
    localparam logic [24:0] VECS [0:5] = '{
        {1'b0, 16'b0101010101010101, 8'h00},
        {1'b1, 16'b0101010101010101, 8'h00},
        {1'b0, 16'b0011001100110011, 8'h10},
        {1'b1, 16'b1111000011110000, 8'hF0},
        {1'b0, 16'b0000000000000000, 8'h77},
        {1'b0, 16'b0110111001011001, 8'hFE}
    };

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_count(input logic [7:0] v);
        cnt_wr = 1'b1; cnt_wdata = v;
        flag_wr = 1'b1; flag_wdata = 1'b1;
        cycles(1);
        cnt_wr = 1'b0; flag_wr = 1'b0; flag_wdata = 1'b0;
    endtask

    // Quiesce: disable, set pin and config, let the synchroniser settle
    task automatic setup(input logic mode, input logic pol, input logic pin,
                         input logic [7:0] start);
        cfg_enable = 1'b0; cfg_mode = mode; cfg_polarity = pol; ext_in = pin;
        cycles(6);
        load_count(start);
    endtask

    function automatic int count_edges(input logic [15:0] pat, input logic pol);
        int n = 0;
        for (int i = 14; i >= 0; i--) begin
            if (pol ? (pat[i+1] && !pat[i]) : (!pat[i+1] && pat[i])) n++;
        end
        return n;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        check("R1", "count after reset", cnt_rdata, 8'h00);
        check("R1", "flag after reset", ovf_flag, 1'b0);
        check("R1", "irq after reset", ovf_irq, 1'b0);

        // Vector table: event counting, both polarities (R3, R4)
        for (int v = 0; v < 6; v++) begin
            logic        pol;
            logic [15:0] pat;
            logic [7:0]  st;
            int          sum;
            {pol, pat, st} = VECS[v];
            setup(1'b0, pol, pat[15], st);
            cfg_enable = 1'b1;
            cycles(1);
            for (int i = 14; i >= 0; i--) begin
                ext_in = pat[i];
                cycles(2);
            end
            cycles(6);
            cfg_enable = 1'b0;
            cycles(1);
            sum = int'(st) + count_edges(pat, pol);
            check(pol ? "R4" : "R3", $sformatf("vector %0d count", v), cnt_rdata, sum % 256);
            check("R10", $sformatf("vector %0d flag", v), ovf_flag, (sum > 255) ? 1 : 0);
        end

        // R2: write with clk_en low and block disabled
        clk_en = 1'b0;
        cnt_wr = 1'b1; cnt_wdata = 8'hA5;
        cycles(1);
        cnt_wr = 1'b0;
        check("R2", "write with clk_en low", cnt_rdata, 8'hA5);
        clk_en = 1'b1;

        // R3: exact latency of three enabled edges
        setup(1'b0, 1'b0, 1'b0, 8'h00);
        cfg_enable = 1'b1;
        cycles(2);
        ext_in = 1'b1;
        cycles(2);
        check("R3", "count two edges after rise", cnt_rdata, 8'h00);
        cycles(1);
        check("R3", "count three edges after rise", cnt_rdata, 8'h01);

        // R4: active-low edges, rising ignored
        setup(1'b0, 1'b1, 1'b0, 8'h20);
        cfg_enable = 1'b1;
        cycles(2);
        ext_in = 1'b1;
        cycles(6);
        check("R4", "rising edge ignored", cnt_rdata, 8'h20);
        ext_in = 1'b0;
        cycles(6);
        check("R4", "falling edge counted", cnt_rdata, 8'h21);

        // R5: toggle at half the enable rate
        setup(1'b0, 1'b0, 1'b0, 8'h00);
        cfg_enable = 1'b1;
        cycles(2);
        for (int t = 0; t < 20; t++) begin
            ext_in = ~ext_in;
            cycles(1);
        end
        cycles(6);
        check("R5", "half-rate toggles", cnt_rdata, 8'd10);

        // R9: clock enable low freezes everything
        clk_en = 1'b0;
        ext_in = 1'b1;
        cycles(10);
        check("R9", "no advance while clk_en low", cnt_rdata, 8'd10);
        ext_in = 1'b0;
        cycles(2);
        clk_en = 1'b1;
        cycles(6);
        check("R9", "hidden pulse not counted", cnt_rdata, 8'd10);

        // R8: disabled block ignores the pin in event mode
        cfg_enable = 1'b0;
        cycles(2);
        for (int t = 0; t < 6; t++) begin
            ext_in = ~ext_in;
            cycles(2);
        end
        cycles(6);
        check("R8", "disabled event mode holds", cnt_rdata, 8'd10);

        // R6: gated time, active high, exact phase
        setup(1'b1, 1'b0, 1'b1, 8'h00);
        cfg_enable = 1'b1;
        cycles(64);
        check("R6", "gated count after 64 edges", cnt_rdata, 8'h00);
        cycles(1);
        check("R6", "gated count after 65 edges", cnt_rdata, 8'h01);
        cycles(64);
        check("R6", "gated count after 129 edges", cnt_rdata, 8'h02);

        // R6: gated time, active low
        setup(1'b1, 1'b1, 1'b0, 8'h00);
        cfg_enable = 1'b1;
        cycles(64 * 3 + 5);
        check("R6", "active-low gated count", cnt_rdata, 8'h03);

        // R7: gated with inactive pin
        setup(1'b1, 1'b0, 1'b0, 8'h33);
        cfg_enable = 1'b1;
        cycles(200);
        check("R7", "inactive gate holds", cnt_rdata, 8'h33);

        // R8: disable holds and restarts prescaler phase
        setup(1'b1, 1'b0, 1'b1, 8'h00);
        cfg_enable = 1'b1;
        cycles(40);
        cfg_enable = 1'b0;
        cycles(100);
        check("R8", "disabled gated holds", cnt_rdata, 8'h00);
        cfg_enable = 1'b1;
        cycles(64);
        check("R8", "prescaler restarted (64 edges)", cnt_rdata, 8'h00);
        cycles(1);
        check("R8", "prescaler restarted (65 edges)", cnt_rdata, 8'h01);

        // R10, R11, R12: wrap, sticky flag, clear, interrupt
        setup(1'b0, 1'b0, 1'b0, 8'hFF);
        cfg_irq_en = 1'b0;
        cfg_enable = 1'b1;
        cycles(2);
        ext_in = 1'b1;
        cycles(2);
        ext_in = 1'b0;
        cycles(6);
        check("R10", "wrap count", cnt_rdata, 8'h00);
        check("R10", "wrap flag", ovf_flag, 1'b1);
        check("R12", "irq masked", ovf_irq, 1'b0);
        cfg_irq_en = 1'b1;
        #1;
        check("R12", "irq enabled", ovf_irq, 1'b1);
        cycles(20);
        check("R10", "flag sticky", ovf_flag, 1'b1);
        flag_wr = 1'b1; flag_wdata = 1'b0;
        cycles(1);
        flag_wr = 1'b0;
        check("R11", "write 0 leaves flag", ovf_flag, 1'b1);
        flag_wr = 1'b1; flag_wdata = 1'b1;
        cycles(1);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        check("R11", "write 1 clears flag", ovf_flag, 1'b0);
        check("R12", "irq drops with flag", ovf_irq, 1'b0);

        // R11: wrap and clear on the same edge
        load_count(8'hFF);
        ext_in = 1'b1;
        cycles(2);
        flag_wr = 1'b1; flag_wdata = 1'b1;
        cycles(1);
        flag_wr = 1'b0; flag_wdata = 1'b0;
        check("R11", "set wins over clear", ovf_flag, 1'b1);
        check("R10", "count wrapped", cnt_rdata, 8'h00);
        ext_in = 1'b0;
        cycles(6);

        // R13: write and increment on the same edge
        load_count(8'hFF);
        ext_in = 1'b1;
        cycles(2);
        cnt_wr = 1'b1; cnt_wdata = 8'h40;
        cycles(1);
        cnt_wr = 1'b0;
        check("R13", "write wins", cnt_rdata, 8'h40);
        check("R13", "no overflow", ovf_flag, 1'b0);
        cycles(6);
        check("R13", "increment dropped", cnt_rdata, 8'h40);
        ext_in = 1'b0;
        cycles(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule